// File: doc/BRIEF.md
# APIC Address Window Decoder

This block keeps a pair of 16-bit configuration registers that describe a memory window for interrupt-controller traffic, and it tells whether a 32-bit memory address falls inside that window. Software programs the registers through a small read/write port addressed by configuration offset. One register holds the window's lower end and an enable bit. The other holds the window's upper end.

Each register stores only address bits 19:9 of its end of the window. Bits 31:20 of both ends are fixed at FECh. Address bits 8:0 of the tested address are ignored. The lower end is widened with bit 8 cleared and the upper end with bit 8 set, so the window is always made of whole 512-byte granules. The hit flag is combinational from the current register contents and the input address.

An offset decoder classifies each access as a base-register access, a limit-register access or no access, using an enumerated selector with a unique case. The names are SEL_NONE, SEL_BASE and SEL_LIMIT. There is no sequential control: the two registers change only on a write strobe to their own offset, and they go back to zero on reset.

Top module: `apic_win_decoder`

## Requirements
- R1: After the active-low synchronous reset, both registers read 0000h and `win_hit` is 0 for every address.
- R2: The base register is at offset 140h. Its bits 11:1 (address bits 19:9 of the lower end) and bit 0 (window enable) are read/write. A write becomes visible on the clock edge that samples `wr_en`.
- R3: The limit register is at offset 142h. Its bits 11:1 (address bits 19:9 of the upper end) are read/write. Its bit 0 always reads 0 and ignores writes.
- R4: Bits 15:12 of both registers always read 0 and ignore writes.
- R5: A read of any offset other than 140h or 142h returns 0. A write to any other offset leaves both registers unchanged.
- R6: `rd_data` is 0 whenever `rd_en` is low. When `rd_en` is high, it is the addressed register's value in the same cycle.
- R7: `win_hit` is 0 whenever the enable bit (base bit 0) is 0.
- R8: `win_hit` is 0 unless `mem_addr[31:20]` equals FECh.
- R9: With the window enabled, an address hits when {FECh, base[11:1], 0} ≤ A[31:8] ≤ {FECh, limit[11:1], 1}. Both ends are included, and A[8:0] has no effect.
- R10: If the base field is greater than the limit field, no address hits, even when the window is enabled.
- R11: `win_hit` follows a change of `mem_addr` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| cfg_offs | input | 12 | Configuration offset for read and write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| mem_addr | input | 32 | Memory address to test against the window |
| rd_data | output | 16 | Read data, 0 when not reading a register |
| win_hit | output | 1 | Address lies inside the enabled window |

## Verification
If a stored field is wrong, the error appears at `rd_data` as soon as that register is read, one edge after the write that caused it. It also appears at `win_hit` in the same cycle that an address near a window edge is presented. A wrong widening of bit 8 would show only at the exact granule boundaries, so the address table places probes one byte inside and one byte outside each end. A wrong enable path or a wrong treatment of the empty window would make `win_hit` go high at an address that should miss, with no delay.

// File: rtl/apic_win_pkg.sv
package apic_win_pkg;
    localparam int unsigned OFFS_W    = 12;
    localparam int unsigned DATA_W    = 16;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned FIELD_W   = 11;
    localparam int unsigned FIELD_LSB = 1;
    localparam int unsigned GRAN_LSB  = 8;
    localparam logic [OFFS_W-1:0] BASE_OFFS  = 12'h140;
    localparam logic [OFFS_W-1:0] LIMIT_OFFS = 12'h142;
    localparam int unsigned HI_W = ADDR_W - GRAN_LSB - FIELD_W - 1;
    localparam logic [HI_W-1:0] FIXED_HI = 12'hFEC;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_BASE  = 2'd1,
        SEL_LIMIT = 2'd2
    } cfg_sel_e;
endpackage

// File: rtl/apic_win_regs.sv
module apic_win_regs
    import apic_win_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OFFS_W-1:0]   cfg_offs,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data,
    output logic [FIELD_W-1:0]  base_fld,
    output logic [FIELD_W-1:0]  lim_fld,
    output logic                win_en
);
    localparam int unsigned RSV_W = DATA_W - FIELD_W - FIELD_LSB;

    cfg_sel_e sel;

    always_comb begin
        unique case (cfg_offs)
            BASE_OFFS:  sel = SEL_BASE;
            LIMIT_OFFS: sel = SEL_LIMIT;
            default:    sel = SEL_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_fld <= '0;
            lim_fld  <= '0;
            win_en   <= 1'b0;
        end else if (wr_en) begin
            if (sel == SEL_BASE) begin
                base_fld <= wr_data[FIELD_LSB +: FIELD_W];
                win_en   <= wr_data[0];
            end
            if (sel == SEL_LIMIT) begin
                lim_fld <= wr_data[FIELD_LSB +: FIELD_W];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_BASE:  rd_data = {{RSV_W{1'b0}}, base_fld, win_en};
                SEL_LIMIT: rd_data = {{RSV_W{1'b0}}, lim_fld, 1'b0};
                default:   rd_data = '0;
            endcase
        end
    end

    // R2
    base_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_offs == BASE_OFFS) |=>
        (base_fld == $past(wr_data[FIELD_LSB +: FIELD_W]) && win_en == $past(wr_data[0])));

    // R5
    other_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_offs != BASE_OFFS && cfg_offs != LIMIT_OFFS) |=>
        ($stable(base_fld) && $stable(lim_fld) && $stable(win_en)));

    // R4
    rsv_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1 -: RSV_W] == '0);

    // R6
    idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);
endmodule

// File: rtl/apic_win_cmp.sv
module apic_win_cmp
    import apic_win_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FIELD_W-1:0]  base_fld,
    input  logic [FIELD_W-1:0]  lim_fld,
    input  logic                win_en,
    input  logic [ADDR_W-1:0]   mem_addr,
    output logic                win_hit
);
    localparam int unsigned CMP_W = ADDR_W - GRAN_LSB;

    logic [CMP_W-1:0] lo_bound;
    logic [CMP_W-1:0] hi_bound;
    logic [CMP_W-1:0] probe;

    always_comb begin
        lo_bound = {FIXED_HI, base_fld, 1'b0};
        hi_bound = {FIXED_HI, lim_fld, 1'b1};
        probe    = mem_addr[ADDR_W-1:GRAN_LSB];
        win_hit  = win_en && (probe >= lo_bound) && (probe <= hi_bound);
    end

    // R7
    hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> win_en);

    // R8
    hit_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> mem_addr[ADDR_W-1 -: HI_W] == FIXED_HI);

    // R10
    empty_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_fld > lim_fld) |-> !win_hit);
endmodule

// File: rtl/apic_win_decoder.sv
module apic_win_decoder
    import apic_win_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OFFS_W-1:0]   cfg_offs,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                win_hit
);
    logic [FIELD_W-1:0] base_fld;
    logic [FIELD_W-1:0] lim_fld;
    logic               win_en;

    apic_win_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .cfg_offs (cfg_offs),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .base_fld (base_fld),
        .lim_fld  (lim_fld),
        .win_en   (win_en)
    );

    apic_win_cmp u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_fld (base_fld),
        .lim_fld  (lim_fld),
        .win_en   (win_en),
        .mem_addr (mem_addr),
        .win_hit  (win_hit)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !win_hit);
endmodule

// File: tb/apic_win_decoder_tb.sv
`timescale 1ns/1ps
module apic_win_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] cfg_offs = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] mem_addr = '0;
    logic [15:0] rd_data;
    logic        win_hit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    apic_win_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_offs(cfg_offs),
        .wr_data(wr_data), .rd_en(rd_en), .mem_addr(mem_addr),
        .rd_data(rd_data), .win_hit(win_hit)
    );

    // {address, expected hit}; base field 010h, limit field 020h, enabled
    localparam logic [32:0] VEC [10] = '{
        {32'hFEC0_2000, 1'b1},   // R9 lowest byte of base granule
        {32'hFEC0_1FFF, 1'b0},   // R9 one byte below
        {32'hFEC0_41FF, 1'b1},   // R9 top byte of limit granule
        {32'hFEC0_4200, 1'b0},   // R9 one byte above
        {32'hFEC0_3000, 1'b1},
        {32'hFEC0_20FF, 1'b1},   // R9 bit 8 clear inside base granule
        {32'hFEC0_4100, 1'b1},   // R9 bit 8 set inside limit granule
        {32'hFED0_3000, 1'b0},   // R8
        {32'h0000_3000, 1'b0},   // R8
        {32'hFEB0_3000, 1'b0}    // R8
    };

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(logic [11:0] offs, logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; cfg_offs = offs; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg_read(logic [11:0] offs, output logic [15:0] val);
        rd_en = 1'b1; cfg_offs = offs;
        #1;
        val = rd_data;
        rd_en = 1'b0;
        #1;
    endtask

    task automatic probe(string tag, logic [31:0] a, logic exp);
        mem_addr = a;
        #1;
        check(tag, {31'd0, win_hit}, {31'd0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cfg_read(12'h140, v); check("R1 base", {16'd0, v}, 0);
        cfg_read(12'h142, v); check("R1 limit", {16'd0, v}, 0);
        probe("R1 hit", 32'hFEC0_0000, 1'b0);

        // R2 R3 R4 all-ones writes
        cfg_write(12'h140, 16'hFFFF);
        cfg_read(12'h140, v); check("R2 R4 base readback", {16'd0, v}, 32'h0FFF);
        cfg_write(12'h142, 16'hFFFF);
        cfg_read(12'h142, v); check("R3 R4 limit readback", {16'd0, v}, 32'h0FFE);

        // R5 write elsewhere, read elsewhere
        cfg_write(12'h144, 16'h0000);
        cfg_write(12'h040, 16'h0000);
        cfg_read(12'h140, v); check("R5 base kept", {16'd0, v}, 32'h0FFF);
        cfg_read(12'h142, v); check("R5 limit kept", {16'd0, v}, 32'h0FFE);
        cfg_read(12'h144, v); check("R5 other read", {16'd0, v}, 0);

        // R6 no read strobe
        cfg_offs = 12'h140; rd_en = 1'b0; #1;
        check("R6 idle rd_data", {16'd0, rd_data}, 0);

        // R2 timing: not visible before the edge
        @(negedge clk);
        wr_en = 1'b1; cfg_offs = 12'h140; wr_data = 16'h0021;
        rd_en = 1'b1; #1;
        check("R2 before edge", {16'd0, rd_data}, 32'h0FFF);
        @(negedge clk);
        wr_en = 1'b0; #1;
        check("R2 after edge", {16'd0, rd_data}, 32'h0021);
        rd_en = 1'b0;
        cfg_write(12'h142, 16'h0040);

        // R9 R8 R11 table
        for (int i = 0; i < 10; i++) begin
            probe($sformatf("R9 R11 vec%0d", i), VEC[i][32:1], VEC[i][0]);
        end

        // R7 disabled window
        cfg_write(12'h140, 16'h0020);
        probe("R7 disabled", 32'hFEC0_3000, 1'b0);

        // R10 base above limit
        cfg_write(12'h140, 16'h0061);
        probe("R10 inverted", 32'hFEC0_3000, 1'b0);
        probe("R10 inverted top", 32'hFEC0_6000, 1'b0);

        // R9 single granule window (base == limit)
        cfg_write(12'h140, 16'h0041);
        probe("R9 single low", 32'hFEC0_4000, 1'b1);
        probe("R9 single high", 32'hFEC0_41FF, 1'b1);
        probe("R9 single above", 32'hFEC0_4200, 1'b0);
        probe("R9 single below", 32'hFEC0_3FFF, 1'b0);

        // R1 reset clears again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        cfg_read(12'h140, v); check("R1 reset base", {16'd0, v}, 0);
        probe("R1 reset hit", 32'hFEC0_4000, 1'b0);

        finish_run();
    end
endmodule